// File: doc/BRIEF.md
# Processor Debug Freeze Controller

This block decides, cycle by cycle, whether a processor core is architecturally frozen for debugging. It sits between the core pipeline, a debug-port command channel and an external halt pin. Two sources can freeze the core: a level-sensitive halt pin and a sticky stop set by the debug port. While the core is frozen, the debug port can release it for exactly one instruction (a step), or it can hand the pipeline one instruction word to execute without leaving the frozen state (a stuff).

The same block also produces a trace trigger pulse from debug-event strobes, but only when every debug mode bit is clear. It selects one of three timer policies, and it turns reset requests from three sources into fixed-length, prioritised reset pulses.

Commands arrive on a valid/ready channel, and a command is consumed in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` drops while a stuffed word waits for the pipeline, so commands are back-pressured until it is taken. Stuffed words leave on a second valid/ready channel. `stuff_word_o` is held stable until `stuff_ready_i` is seen high. All other pins are plain levels or strobes.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: The cycle after any `dbg_evt_i` bit is sampled high, `trace_trig_o` is high for one cycle, but only if `mode_int_i`, `mode_ext_i` and `mode_wait_i` were all low in that same cycle; otherwise no trigger is produced.
- R2: `freeze_o` goes high the cycle after `halt_i` is sampled high. It goes low the cycle after `halt_i` is sampled low, unless a stop is pending.
- R3: Command codes on `cmd_op_i` are 0 stop, 1 run, 2 step, 3 stuff, 4 set timer policy from `cmd_data_i[1:0]`, 5 core reset, 6 chip reset, 7 system reset. A consumed stop freezes the core until a consumed run clears it. A run consumed while `halt_i` is high leaves the core frozen.
- R4: A step consumed while frozen makes `issue_ok_o` high and `freeze_o` low for exactly the next cycle, after which the core is frozen again. A step consumed while running has no effect.
- R5: A stuff consumed while frozen raises `stuff_valid_o` with the `cmd_data_i` word on the next cycle. The word is held until `stuff_ready_i` is sampled high, `cmd_ready_o` stays low for that whole time, and `freeze_o` is not affected. A stuff consumed while running is discarded.
- R6: The timer policy is 00 always run, 01 always frozen, 10 frozen after a debug event, and 11 behaves as always run. It can be written by command 4 or by `ctl_tmr_we_i` with `ctl_tmr_pol_i`. If both write in the same cycle, the command wins.
- R7: Under policy 10, a debug event drops `tmr_en_o` from the next cycle on. It stays low until the frozen state ends (frozen in one cycle, running in the next). A new event in that same cycle keeps it low.
- R8: Each of core, chip and system reset can be requested by `ext_rst_i`, `ctl_rst_i` (bit 0 core, bit 1 chip, bit 2 system) or the matching debug-port command.
- R9: An accepted reset request drives exactly one reset output for 4 cycles, starting the cycle after it is sampled. Among requests arriving together, system beats chip and chip beats core. Requests sampled while a pulse is running are dropped.
- R10: After reset, `freeze_o`, `issue_ok_o`, `stuff_valid_o`, `trace_trig_o` and all reset outputs are low, `cmd_ready_o` and `tmr_en_o` are high, and the timer policy is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_evt_i | input | NUM_EVT | Debug-event strobes |
| mode_int_i | input | 1 | Internal debug mode bit |
| mode_ext_i | input | 1 | External debug mode bit |
| mode_wait_i | input | 1 | Debug wait mode bit |
| halt_i | input | 1 | External halt level |
| cmd_valid_i | input | 1 | Debug-port command valid |
| cmd_ready_o | output | 1 | Debug-port command ready |
| cmd_op_i | input | 3 | Command code |
| cmd_data_i | input | INSN_W | Stuff word or timer policy |
| stuff_valid_o | output | 1 | Stuffed instruction valid |
| stuff_ready_i | input | 1 | Pipeline takes stuffed instruction |
| stuff_word_o | output | INSN_W | Stuffed instruction word |
| freeze_o | output | 1 | Core frozen |
| issue_ok_o | output | 1 | One-instruction issue permit |
| trace_trig_o | output | 1 | Trace trigger pulse |
| ctl_tmr_we_i | input | 1 | Control-register timer policy write |
| ctl_tmr_pol_i | input | 2 | Control-register timer policy |
| ctl_rst_i | input | 3 | Control-register reset requests |
| ext_rst_i | input | 3 | External reset requests |
| tmr_en_o | output | 1 | Timers may tick |
| rst_core_o | output | 1 | Core reset pulse |
| rst_chip_o | output | 1 | Chip reset pulse |
| rst_sys_o | output | 1 | System reset pulse |

## Verification
The freeze logic is driven with three kinds of pattern. Halt is toggled with no commands, which shows that the pin alone is level-driven. Run is issued while halt is high, which separates an OR of the two sources from a run that overrides halt. Steps and stuffs are sent both while frozen and while running, which shows that they are qualified by the frozen state. Long random runs mix events, mode bits, policy writes from both sources and stuff back-pressure. Those runs expose off-by-one pulse timing, a lost priority between policy writers, and an event-freeze that clears on a step instead of a true resume. Reset requests from all three sources arriving in one cycle, and again during a running pulse, show the scope priority and that late requests are dropped.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [2:0] {
    OP_STOP  = 3'd0,
    OP_RUN   = 3'd1,
    OP_STEP  = 3'd2,
    OP_STUFF = 3'd3,
    OP_TMR   = 3'd4,
    OP_RCORE = 3'd5,
    OP_RCHIP = 3'd6,
    OP_RSYS  = 3'd7
  } dbg_op_e;

  typedef enum logic [1:0] {
    TMR_RUN    = 2'b00,
    TMR_HOLD   = 2'b01,
    TMR_ON_EVT = 2'b10,
    TMR_RSVD   = 2'b11
  } tmr_pol_e;

  localparam int unsigned NSCOPE = 3;  // 0 core, 1 chip, 2 system
endpackage

// File: rtl/dfc_run_ctl.sv
module dfc_run_ctl
  import dfc_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              cmd_acc_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [INSN_W-1:0] cmd_data_i,
  input  logic              stuff_ready_i,
  output logic              held_o,
  output logic              freeze_o,
  output logic              issue_ok_o,
  output logic              stuff_valid_o,
  output logic [INSN_W-1:0] stuff_word_o
);
  dbg_op_e op;
  logic stop_q, halt_q, step_q, svld_q;
  logic [INSN_W-1:0] word_q;

  assign op = dbg_op_e'(cmd_op_i);
  assign held_o = stop_q | halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      halt_q <= 1'b0;
      step_q <= 1'b0;
      svld_q <= 1'b0;
      word_q <= '0;
    end else begin
      halt_q <= halt_i;
      step_q <= cmd_acc_i && (op == OP_STEP) && held_o;
      if (cmd_acc_i && (op == OP_STOP))      stop_q <= 1'b1;
      else if (cmd_acc_i && (op == OP_RUN))  stop_q <= 1'b0;
      if (svld_q && stuff_ready_i) svld_q <= 1'b0;
      if (cmd_acc_i && (op == OP_STUFF) && held_o) begin
        svld_q <= 1'b1;
        word_q <= cmd_data_i;
      end
    end
  end

  assign freeze_o      = held_o & ~step_q;
  assign issue_ok_o    = step_q;
  assign stuff_valid_o = svld_q;
  assign stuff_word_o  = word_q;

  // R4: a permit only follows a frozen cycle
  a_r4_step_from_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok_o |-> $past(held_o));
  // R3: run while halt is high keeps the core frozen
  a_r3_run_under_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc_i && (op == OP_RUN) && halt_i) |=> freeze_o);
  // R5: a waiting stuffed word is held stable
  a_r5_stuff_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_valid_o && !stuff_ready_i) |=> (stuff_valid_o && $stable(stuff_word_o)));
endmodule

// File: rtl/dfc_trace_tmr.sv
module dfc_trace_tmr
  import dfc_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               mode_int_i,
  input  logic               mode_ext_i,
  input  logic               mode_wait_i,
  input  logic               held_i,
  input  logic               port_we_i,
  input  logic [1:0]         port_pol_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_pol_i,
  output logic               trig_o,
  output logic               tmr_en_o
);
  logic     any_evt, trig_q, hd_q, evf_q;
  tmr_pol_e pol_q;

  assign any_evt = |evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      hd_q   <= 1'b0;
      evf_q  <= 1'b0;
      pol_q  <= TMR_RUN;
    end else begin
      trig_q <= any_evt & ~(mode_int_i | mode_ext_i | mode_wait_i);
      hd_q   <= held_i;
      if (port_we_i)     pol_q <= tmr_pol_e'(port_pol_i);
      else if (reg_we_i) pol_q <= tmr_pol_e'(reg_pol_i);
      if ((pol_q == TMR_ON_EVT) && any_evt) evf_q <= 1'b1;
      else if (hd_q && !held_i)             evf_q <= 1'b0;
    end
  end

  assign trig_o   = trig_q;
  assign tmr_en_o = (pol_q != TMR_HOLD) && !((pol_q == TMR_ON_EVT) && evf_q);

  // R1: any mode bit set blocks the trigger
  a_r1_mode_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (any_evt && (mode_int_i || mode_ext_i || mode_wait_i)) |=> !trig_o);
  // R6: writing the always-frozen policy stops the timers
  a_r6_hold_policy: assert property (@(posedge clk) disable iff (!rst_n)
    (port_we_i && (port_pol_i == 2'b01)) |=> !tmr_en_o);
  // R7: an event under the event policy stops the timers
  a_r7_evt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ((pol_q == TMR_ON_EVT) && any_evt && !port_we_i && !reg_we_i) |=> !tmr_en_o);
endmodule

// File: rtl/dfc_rst_gen.sv
module dfc_rst_gen
  import dfc_pkg::*;
#(
  parameter int unsigned RST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSCOPE-1:0] req_i,
  output logic [NSCOPE-1:0] rst_o
);
  localparam int unsigned CNT_W = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_LEN - 1);

  logic [NSCOPE-1:0] scope_q, pick;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    pick = '0;
    if (req_i[2])      pick[2] = 1'b1;
    else if (req_i[1]) pick[1] = 1'b1;
    else if (req_i[0]) pick[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scope_q <= '0;
      cnt_q   <= '0;
    end else if (scope_q == '0) begin
      if (req_i != '0) begin
        scope_q <= pick;
        cnt_q   <= LAST;
      end
    end else if (cnt_q == '0) begin
      scope_q <= '0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rst_o = scope_q;

  // R9: never more than one reset scope at a time
  a_r9_one_scope: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_o));
  // R9: a running pulse keeps its scope until its count expires
  a_r9_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_o != '0) && (cnt_q != '0)) |=> $stable(rst_o));
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
  import dfc_pkg::*;
#(
  parameter int unsigned INSN_W  = 32,
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned RST_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] dbg_evt_i,
  input  logic               mode_int_i,
  input  logic               mode_ext_i,
  input  logic               mode_wait_i,
  input  logic               halt_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [2:0]         cmd_op_i,
  input  logic [INSN_W-1:0]  cmd_data_i,
  output logic               stuff_valid_o,
  input  logic               stuff_ready_i,
  output logic [INSN_W-1:0]  stuff_word_o,
  output logic               freeze_o,
  output logic               issue_ok_o,
  output logic               trace_trig_o,
  input  logic               ctl_tmr_we_i,
  input  logic [1:0]         ctl_tmr_pol_i,
  input  logic [2:0]         ctl_rst_i,
  input  logic [2:0]         ext_rst_i,
  output logic               tmr_en_o,
  output logic               rst_core_o,
  output logic               rst_chip_o,
  output logic               rst_sys_o
);
  logic              cmd_acc, held, port_we;
  logic [NSCOPE-1:0] rst_req, rst_pulse;

  assign cmd_ready_o = ~stuff_valid_o;
  assign cmd_acc     = cmd_valid_i & cmd_ready_o;
  assign port_we     = cmd_acc && (cmd_op_i == 3'(OP_TMR));

  for (genvar s = 0; s < NSCOPE; s++) begin : g_req
    assign rst_req[s] = ext_rst_i[s] | ctl_rst_i[s] |
                        (cmd_acc && (cmd_op_i == 3'(32'(OP_RCORE) + s)));
  end

  dfc_run_ctl #(.INSN_W(INSN_W)) run_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .cmd_acc_i(cmd_acc),
    .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i), .stuff_ready_i(stuff_ready_i),
    .held_o(held), .freeze_o(freeze_o), .issue_ok_o(issue_ok_o),
    .stuff_valid_o(stuff_valid_o), .stuff_word_o(stuff_word_o)
  );

  dfc_trace_tmr #(.NUM_EVT(NUM_EVT)) trc_i (
    .clk(clk), .rst_n(rst_n), .evt_i(dbg_evt_i), .mode_int_i(mode_int_i),
    .mode_ext_i(mode_ext_i), .mode_wait_i(mode_wait_i), .held_i(held),
    .port_we_i(port_we), .port_pol_i(cmd_data_i[1:0]), .reg_we_i(ctl_tmr_we_i),
    .reg_pol_i(ctl_tmr_pol_i), .trig_o(trace_trig_o), .tmr_en_o(tmr_en_o)
  );

  dfc_rst_gen #(.RST_LEN(RST_LEN)) rst_i (
    .clk(clk), .rst_n(rst_n), .req_i(rst_req), .rst_o(rst_pulse)
  );

  assign rst_core_o = rst_pulse[0];
  assign rst_chip_o = rst_pulse[1];
  assign rst_sys_o  = rst_pulse[2];

  // R5: commands are blocked while a stuffed word waits
  a_r5_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_valid_o |-> !cmd_ready_o);
endmodule

// File: tb/dbg_freeze_ctrl_tb_top.sv
module dbg_freeze_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [3:0]  dbg_evt;
  logic        mi, me, mw, halt, cvld, crdy, svld, srdy;
  logic [2:0]  cop, crst, xrst;
  logic [31:0] cdat, sword;
  logic        frz, iok, trig, twe, ten, rc, rh, rs;
  logic [1:0]  tpol;

  dbg_freeze_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_evt_i(dbg_evt), .mode_int_i(mi), .mode_ext_i(me),
    .mode_wait_i(mw), .halt_i(halt), .cmd_valid_i(cvld), .cmd_ready_o(crdy),
    .cmd_op_i(cop), .cmd_data_i(cdat), .stuff_valid_o(svld), .stuff_ready_i(srdy),
    .stuff_word_o(sword), .freeze_o(frz), .issue_ok_o(iok), .trace_trig_o(trig),
    .ctl_tmr_we_i(twe), .ctl_tmr_pol_i(tpol), .ctl_rst_i(crst), .ext_rst_i(xrst),
    .tmr_en_o(ten), .rst_core_o(rc), .rst_chip_o(rh), .rst_sys_o(rs)
  );

  int errs = 0, nchk = 0;
  bit done = 0;
  bit m_stop, m_halt, m_step, m_svld, m_evf, m_hd, m_trig;
  logic [31:0] m_word;
  logic [1:0]  m_pol;
  logic [2:0]  m_scope;
  int          m_cnt;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] pick3(input logic [2:0] r);
    return r[2] ? 3'b100 : r[1] ? 3'b010 : r[0] ? 3'b001 : 3'b000;
  endfunction

  function automatic bit exp_ten();
    return (m_pol != 2'b01) && !((m_pol == 2'b10) && m_evf);
  endfunction

  task automatic model_update();
    bit acc, held;
    logic [2:0] req;
    if (!rst_n) begin
      m_stop = 0; m_halt = 0; m_step = 0; m_svld = 0; m_evf = 0; m_hd = 0;
      m_trig = 0; m_word = 0; m_pol = 0; m_scope = 0; m_cnt = 0;
      return;
    end
    acc  = cvld && !m_svld;
    held = m_stop || m_halt;
    for (int s = 0; s < 3; s++)
      req[s] = xrst[s] | crst[s] | (acc && (cop == 3'(5 + s)));
    if (m_scope == 0) begin
      if (req != 0) begin m_scope = pick3(req); m_cnt = 3; end
    end else if (m_cnt == 0) m_scope = 0;
    else m_cnt--;
    if ((m_pol == 2'b10) && (dbg_evt != 0)) m_evf = 1;
    else if (m_hd && !held) m_evf = 0;
    m_hd = held;
    if (acc && cop == 3'd4) m_pol = cdat[1:0];
    else if (twe) m_pol = tpol;
    m_trig = (dbg_evt != 0) && !(mi || me || mw);
    if (m_svld && srdy) m_svld = 0;
    if (acc && cop == 3'd3 && held) begin m_svld = 1; m_word = cdat; end
    m_step = acc && cop == 3'd2 && held;
    if (acc && cop == 3'd0) m_stop = 1;
    else if (acc && cop == 3'd1) m_stop = 0;
    m_halt = halt;
  endtask

  task automatic compare();
    chk("R3 freeze", frz, (m_stop | m_halt) & ~m_step);
    chk("R4 issue_ok", iok, m_step);
    chk("R5 stuff_valid", svld, m_svld);
    if (m_svld) chk("R5 stuff_word", sword, m_word);
    chk("R5 cmd_ready", crdy, !m_svld);
    chk("R1 trigger", trig, m_trig);
    chk("R7 tmr_en", ten, exp_ten());
    chk("R9 resets", {rs, rh, rc}, m_scope);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    dbg_evt = 0; mi = 0; me = 0; mw = 0; cvld = 0; cop = 0; cdat = 0;
    srdy = 1; twe = 0; tpol = 0; crst = 0; xrst = 0;
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] d);
    cvld = 1; cop = op; cdat = d;
    cyc();
    cvld = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    idle(); halt = 0; rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R10 reset state
    chk("R10 freeze", frz, 0); chk("R10 cmd_ready", crdy, 1);
    chk("R10 tmr_en", ten, 1); chk("R10 resets", {rs, rh, rc}, 0);
    chk("R10 trigger", trig, 0); chk("R10 stuff_valid", svld, 0);
    // R2 halt alone
    halt = 1; cyc(); chk("R2 halt freezes", frz, 1);
    halt = 0; cyc(); chk("R2 halt release", frz, 0);
    // R3 run under halt, R4 step, R5 stuff with back-pressure
    halt = 1; cyc();
    send(3'd1, 0); chk("R3 run under halt", frz, 1);
    send(3'd2, 0); chk("R4 step permit", iok, 1); chk("R4 step unfreeze", frz, 0);
    cyc(); chk("R4 refreeze", frz, 1);
    srdy = 0; send(3'd3, 32'hCAFE_F00D);
    chk("R5 stuff out", sword, 32'hCAFE_F00D); chk("R5 still frozen", frz, 1);
    cyc(); chk("R5 ready low", crdy, 0);
    srdy = 1; cyc(); chk("R5 taken", svld, 0);
    halt = 0; cyc();
    send(3'd2, 0); chk("R4 step ignored running", iok, 0);
    // R6 policy writers
    twe = 1; tpol = 2'b01; cyc(); twe = 0; chk("R6 reg hold", ten, 0);
    twe = 1; tpol = 2'b01; send(3'd4, 32'd0); twe = 0; chk("R6 port wins", ten, 1);
    // R7 event freeze then resume
    send(3'd4, 32'd2);
    dbg_evt = 4'b0010; cyc(); dbg_evt = 0; chk("R7 event stops", ten, 0);
    send(3'd0, 0); cyc(); chk("R7 stays frozen", ten, 0);
    send(3'd1, 0); cyc(); chk("R7 resume restarts", ten, 1);
    // R8 and R9 reset sources, priority, length
    xrst = 3'b001; crst = 3'b010; send(3'd7, 0); xrst = 0; crst = 0;
    chk("R9 system wins", {rs, rh, rc}, 3'b100);
    crst = 3'b001; cyc(); crst = 0; chk("R9 dropped while busy", {rs, rh, rc}, 3'b100);
    repeat (2) cyc(); chk("R9 fourth cycle", rs, 1);
    cyc(); chk("R9 pulse over", rs, 0);
    crst = 3'b010; cyc(); crst = 0; chk("R8 control chip", rh, 1);
    repeat (4) cyc();
    xrst = 3'b001; cyc(); xrst = 0; chk("R8 external core", rc, 1);
    repeat (4) cyc();
    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      dbg_evt = ($urandom % 5 == 0) ? 4'($urandom) : 4'd0;
      mi = ($urandom % 4 == 0); me = ($urandom % 4 == 0); mw = ($urandom % 4 == 0);
      if ($urandom % 20 == 0) halt = ~halt;
      cvld = ($urandom % 3 == 0);
      r = $urandom % 16;
      cop = (r < 3) ? 3'd0 : (r < 6) ? 3'd1 : (r < 9) ? 3'd2 : (r < 12) ? 3'd3 :
            (r < 14) ? 3'd4 : 3'(5 + $urandom % 3);
      cdat = $urandom;
      srdy = ($urandom % 2 == 0);
      twe = ($urandom % 15 == 0); tpol = 2'($urandom);
      crst = ($urandom % 40 == 0) ? 3'($urandom) : 3'd0;
      xrst = ($urandom % 40 == 0) ? 3'($urandom) : 3'd0;
      cyc();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule